// File: doc/BRIEF.md
# Size-Scaled Effective Address Generator

This block turns a 32-bit memory-referencing instruction into the byte address of its operand. The instruction holds a 17-bit word reference, a 3-bit index designator and an indirect flag. The index register's contents are treated as an element count and not as a byte offset. The count is shifted by the operand size before it is added to the reference, so an index of k reaches the k-th byte, halfword, word or doubleword from the base, whatever the element size. A doubleword base is first forced down to an even word.

When the indirect flag is set, the block reads one word from memory through a request/acknowledge port. The low 17 bits of that word become the new reference, and the index is added after this fetch (post-indexing). Only one level of indirection is followed. The block also raises a flag when the result lands in the first sixteen words, which name general registers rather than memory.

The controller has three states. `ST_IDLE` waits for a start strobe. On a direct instruction it takes the transition *load-direct* to `ST_DONE`. On an indirect instruction it takes *begin-fetch* to `ST_FETCH`. `ST_FETCH` holds the memory request until acknowledge, then takes *load-indirect* to `ST_DONE`. `ST_DONE` drives the done strobe for one cycle and takes *retire* back to `ST_IDLE`.

Top module: `sized_ea_unit`

## Requirements
- R1: After reset, `done`, `mem_req`, `in_regs` are 0 and `ea_byte` is 0.
- R2: For a direct instruction (instr[31]=0), `done` is high in the cycle right after the start strobe. It carries the result computed from the instruction and from the register value read in the start cycle.
- R3: The result equals reference×4 + (index value << s), taken modulo 2^EA_W. The shift s is 0, 1, 2 or 3 for `op_size` codes 0 (byte), 1 (halfword), 2 (word) and 3 (doubleword). The reference is instr[16:0].
- R4: For `op_size`=3, bit 0 of the word reference is cleared before it is scaled and added.
- R5: The index designator is instr[19:17]. The block reads register {0, designator} through `reg_rd_idx`/`reg_rd_data`. A designator of 0 means an index of zero, whatever register 0 holds.
- R6: For an indirect instruction (instr[31]=1), `mem_req` rises the cycle after start. `mem_addr` equals the unindexed instr[16:0], and both hold until `mem_ack`.
- R7: On acknowledge, the reference is replaced by `mem_rdata`[16:0]; upper bits are ignored. The index captured at start is then applied, and `done` is high the cycle after the acknowledge cycle.
- R8: `in_regs` is 1 exactly when `ea_byte` divided by 4 is below 16.
- R9: A start strobe while a fetch is outstanding is ignored. It produces no extra result and does not disturb `mem_addr`.
- R10: `done` lasts one cycle. `ea_byte` and `in_regs` hold their values until the next `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin address generation for `instr` |
| instr | input | 32 | Instruction word |
| op_size | input | 2 | Operand size code: 0 byte, 1 halfword, 2 word, 3 doubleword |
| reg_rd_idx | output | 4 | Register file read select |
| reg_rd_data | input | DATA_W | Register file read data, same cycle |
| mem_req | output | 1 | Indirect word read request |
| mem_addr | output | 17 | Word address of indirect read |
| mem_ack | input | 1 | Read data valid, ends request |
| mem_rdata | input | DATA_W | Indirect word |
| ea_byte | output | EA_W | Effective byte address |
| in_regs | output | 1 | Result lies in the general-register window |
| done | output | 1 | One-cycle result strobe |

## Verification
A new start strobe and an outstanding indirect fetch can coincide. The bench provokes this by pulsing start with a different instruction two cycles into a fetch whose acknowledge is delayed. It then judges that `mem_addr` still holds the first reference at acknowledge time. It also judges that exactly one result appears, and that this result matches the scoreboard entry for the first instruction. The acknowledge and the final addition likewise share one cycle. Their timing is judged against the cycle in which the memory model raised acknowledge.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int INSTR_W = 32;
    localparam int REF_W   = 17;
    localparam int XSEL_W  = 3;
    localparam int RSEL_W  = XSEL_W + 1;
    localparam int WORD_SH = 2;

    typedef enum logic [1:0] {
        SZ_BYTE   = 2'd0,
        SZ_HALF   = 2'd1,
        SZ_WORD   = 2'd2,
        SZ_DOUBLE = 2'd3
    } opsize_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DONE  = 2'd2
    } ea_state_e;
endpackage

// File: rtl/ea_field_split.sv
module ea_field_split
    import ea_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output logic               ind_o,
    output logic [XSEL_W-1:0]  xsel_o,
    output logic [REF_W-1:0]   ref_o
);
    localparam int IND_POS = INSTR_W - 1;
    localparam int XSEL_LO = REF_W;
    localparam int SKIP_LO = XSEL_LO + XSEL_W;

    assign ind_o  = instr_i[IND_POS];
    assign xsel_o = instr_i[XSEL_LO +: XSEL_W];
    assign ref_o  = instr_i[REF_W-1:0];

    // opcode and register fields belong to other units
    logic unused_fields;
    assign unused_fields = ^instr_i[IND_POS-1:SKIP_LO];
endmodule

// File: rtl/ea_scale_add.sv
module ea_scale_add
    import ea_pkg::*;
#(
    parameter int EA_W      = 24,
    parameter int DATA_W    = 32,
    parameter int WIN_WORDS = 16
) (
    input  logic [REF_W-1:0]  ref_i,
    input  logic [DATA_W-1:0] idx_i,
    input  opsize_e           size_i,
    output logic [EA_W-1:0]   ea_o,
    output logic              in_win_o
);
    localparam int N_SIZES = 4;
    localparam int WIN_SH  = $clog2(WIN_WORDS) + WORD_SH;

    logic [EA_W-1:0]  scaled [N_SIZES];
    logic [EA_W-1:0]  idx_t;
    logic [REF_W-1:0] ref_al;
    logic [EA_W-1:0]  base;

    assign idx_t = EA_W'(idx_i);

    generate
        for (genvar g = 0; g < N_SIZES; g++) begin : g_scale
            assign scaled[g] = idx_t << g;
        end
    endgenerate

    always_comb begin
        ref_al = ref_i;
        if (size_i == SZ_DOUBLE) begin
            ref_al[0] = 1'b0;
        end
    end

    assign base     = EA_W'({ref_al, {WORD_SH{1'b0}}});
    assign ea_o     = base + scaled[size_i];
    assign in_win_o = (ea_o[EA_W-1:WIN_SH] == '0);
endmodule

// File: rtl/sized_ea_unit.sv
module sized_ea_unit
    import ea_pkg::*;
#(
    parameter int EA_W      = 24,
    parameter int DATA_W    = 32,
    parameter int WIN_WORDS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [INSTR_W-1:0] instr,
    input  logic [1:0]         op_size,
    output logic [RSEL_W-1:0]  reg_rd_idx,
    input  logic [DATA_W-1:0]  reg_rd_data,
    output logic               mem_req,
    output logic [REF_W-1:0]   mem_addr,
    input  logic               mem_ack,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [EA_W-1:0]    ea_byte,
    output logic               in_regs,
    output logic               done
);
    localparam int WIN_BYTES = WIN_WORDS * (1 << WORD_SH);

    ea_state_e st_q, st_d;

    logic              dec_ind;
    logic [XSEL_W-1:0] dec_x;
    logic [REF_W-1:0]  dec_ref;

    logic [REF_W-1:0]  ref_q;
    logic [DATA_W-1:0] idx_q;
    opsize_e           size_q;
    logic [EA_W-1:0]   ea_q;
    logic              win_q;

    logic [REF_W-1:0]  add_ref;
    logic [DATA_W-1:0] add_idx;
    logic [DATA_W-1:0] live_idx;
    opsize_e           add_size;
    logic [EA_W-1:0]   add_ea;
    logic              add_win;
    logic              accept;
    logic              load_ea;

    ea_field_split u_split (
        .instr_i (instr),
        .ind_o   (dec_ind),
        .xsel_o  (dec_x),
        .ref_o   (dec_ref)
    );

    assign reg_rd_idx = {{(RSEL_W-XSEL_W){1'b0}}, dec_x};
    assign live_idx   = (dec_x == '0) ? '0 : reg_rd_data;
    assign accept     = (st_q == ST_IDLE) && start;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions: load-direct, begin-fetch, load-indirect, retire
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start) begin
                    st_d = dec_ind ? ST_FETCH : ST_DONE;
                end
            end
            ST_FETCH: begin
                if (mem_ack) begin
                    st_d = ST_DONE;
                end
            end
            ST_DONE:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    // outputs of each state
    always_comb begin
        mem_req = 1'b0;
        done    = 1'b0;
        load_ea = 1'b0;
        unique case (st_q)
            ST_IDLE:  load_ea = start && !dec_ind;
            ST_FETCH: begin
                mem_req = 1'b1;
                load_ea = mem_ack;
            end
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end

    // adder operands: live fields when idle, captured ones during fetch
    always_comb begin
        if (st_q == ST_FETCH) begin
            add_ref  = mem_rdata[REF_W-1:0];
            add_idx  = idx_q;
            add_size = size_q;
        end else begin
            add_ref  = dec_ref;
            add_idx  = live_idx;
            add_size = opsize_e'(op_size);
        end
    end

    ea_scale_add #(
        .EA_W      (EA_W),
        .DATA_W    (DATA_W),
        .WIN_WORDS (WIN_WORDS)
    ) u_scale (
        .ref_i    (add_ref),
        .idx_i    (add_idx),
        .size_i   (add_size),
        .ea_o     (add_ea),
        .in_win_o (add_win)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q  <= '0;
            idx_q  <= '0;
            size_q <= SZ_BYTE;
            ea_q   <= '0;
            win_q  <= 1'b0;
        end else begin
            if (accept) begin
                ref_q  <= dec_ref;
                idx_q  <= live_idx;
                size_q <= opsize_e'(op_size);
            end
            if (load_ea) begin
                ea_q  <= add_ea;
                win_q <= add_win;
            end
        end
    end

    assign mem_addr = ref_q;
    assign ea_byte  = ea_q;
    assign in_regs  = win_q;

    logic unused_rdata;
    assign unused_rdata = ^mem_rdata[DATA_W-1:REF_W];

    // R2: direct instruction completes next cycle
    p_direct_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req && !done && start && !instr[INSTR_W-1]) |=> done);

    // R6: request and its address hold until acknowledge
    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R7: acknowledge leads to a result and ends the request
    p_ack_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (done && !mem_req));

    // R8: window flag agrees with the published address
    p_win_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (in_regs == (ea_byte < EA_W'(WIN_BYTES))));

    // R9: start during a pending fetch yields no result
    p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && start) |=> !done);

    // R10: single-cycle strobe
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: result holds between strobes
    p_ea_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(ea_byte) && $stable(in_regs)));
endmodule

// File: tb/sized_ea_unit_bench.sv
module sized_ea_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam int EA_W       = 24;
    localparam int DATA_W     = 32;
    localparam int WD_CYCLES  = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [31:0]       instr = '0;
    logic [1:0]        op_size = '0;
    logic [3:0]        reg_rd_idx;
    logic [DATA_W-1:0] reg_rd_data;
    logic              mem_req;
    logic [16:0]       mem_addr;
    logic              mem_ack = 1'b0;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic [EA_W-1:0]   ea_byte;
    logic              in_regs;
    logic              done;

    logic [31:0] regs [16];
    assign reg_rd_data = regs[reg_rd_idx];

    sized_ea_unit #(.EA_W(EA_W), .DATA_W(DATA_W), .WIN_WORDS(16)) u_sized_ea_unit (
        .clk, .rst_n, .start, .instr, .op_size, .reg_rd_idx, .reg_rd_data,
        .mem_req, .mem_addr, .mem_ack, .mem_rdata, .ea_byte, .in_regs, .done
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int n_issued = 0;
    int n_seen = 0;
    int ack_cyc = 0;
    int wait_cnt = 0;
    int mem_lat = 0;
    logic [31:0] mem_word = '0;
    logic [16:0] exp_ind_addr = '0;
    bit finished = 1'b0;

    logic [EA_W-1:0] q_ea [$];
    logic            q_win [$];
    bit              q_ind [$];
    int              q_cyc [$];
    string           q_tag [$];

    logic [EA_W-1:0] last_ea = '0;
    logic            prev_done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    function automatic logic [EA_W-1:0] model_ea(input logic [16:0] rw, input logic [31:0] idx, input int sz);
        logic [16:0] b;
        b = rw;
        if (sz == 3) b[0] = 1'b0;
        return EA_W'({b, 2'b00}) + EA_W'(idx << sz);
    endfunction

    // memory responder with programmable latency
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (wait_cnt >= mem_lat) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem_word;
                ack_cyc   <= cyc;
                wait_cnt  <= 0;
                chk(mem_addr == exp_ind_addr, "R6 indirect address", 32'(mem_addr), 32'(exp_ind_addr));
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                chk(!prev_done, "R10 strobe width", 32'(prev_done), 32'd0);
                if (q_ea.size() == 0) begin
                    chk(1'b0, "R9 unexpected result", 32'(ea_byte), 32'd0);
                end else begin
                    logic [EA_W-1:0] e_ea;
                    logic            e_win;
                    bit              e_ind;
                    int              e_cyc;
                    string           e_tag;
                    e_ea  = q_ea.pop_front();
                    e_win = q_win.pop_front();
                    e_ind = q_ind.pop_front();
                    e_cyc = q_cyc.pop_front();
                    e_tag = q_tag.pop_front();
                    chk(ea_byte == e_ea, e_tag, 32'(ea_byte), 32'(e_ea));
                    chk(in_regs == e_win, "R8 window flag", 32'(in_regs), 32'(e_win));
                    if (e_ind)
                        chk(cyc == ack_cyc + 1, "R7 done after ack", 32'(cyc), 32'(ack_cyc + 1));
                    else
                        chk(cyc == e_cyc + 1, "R2 done after start", 32'(cyc), 32'(e_cyc + 1));
                end
                n_seen++;
            end else begin
                chk(ea_byte == last_ea, "R10 result hold", 32'(ea_byte), 32'(last_ea));
            end
            last_ea   = ea_byte;
            prev_done = done;
        end
    end

    // driver: pushes expected item, then strobes start
    task automatic issue(input bit ind, input logic [2:0] x, input logic [16:0] rf, input int sz,
                         input logic [31:0] iword, input int lat, input bit poke, input string tag);
        logic [31:0] idx;
        logic [16:0] r;
        logic [EA_W-1:0] e;
        @(negedge clk);
        idx = (x == 3'd0) ? 32'd0 : regs[{1'b0, x}];
        r   = ind ? iword[16:0] : rf;
        e   = model_ea(r, idx, sz);
        q_ea.push_back(e);
        q_win.push_back(e < EA_W'(64));
        q_ind.push_back(ind);
        q_cyc.push_back(cyc);
        q_tag.push_back(tag);
        n_issued++;
        exp_ind_addr = rf;
        mem_word     = iword;
        mem_lat      = lat;
        instr   = {ind, 7'h2A, 4'h9, x, rf};
        op_size = sz[1:0];
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            @(negedge clk);
            instr   = {1'b0, 7'h11, 4'h2, 3'd2, 17'h00003};
            op_size = 2'd0;
            start   = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait (n_seen == n_issued);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) regs[i] = 32'h0;
        regs[0] = 32'hDEAD_BEEF;
        regs[1] = 32'd5;
        regs[2] = 32'd3;
        regs[3] = 32'd100;
        regs[7] = 32'd1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(done == 1'b0,    "R1 done",    32'(done),    32'd0);
        chk(mem_req == 1'b0, "R1 mem_req", 32'(mem_req), 32'd0);
        chk(in_regs == 1'b0, "R1 in_regs", 32'(in_regs), 32'd0);
        chk(ea_byte == '0,   "R1 ea_byte", 32'(ea_byte), 32'd0);

        // R2/R5: no index, register 0 content must not leak
        issue(1'b0, 3'd0, 17'h00100, 0, 32'h0, 0, 1'b0, "R5 no index");
        // R3: all four sizes with index 5
        issue(1'b0, 3'd1, 17'h00100, 0, 32'h0, 0, 1'b0, "R3 byte index");
        issue(1'b0, 3'd1, 17'h00100, 1, 32'h0, 0, 1'b0, "R3 halfword index");
        issue(1'b0, 3'd1, 17'h00100, 2, 32'h0, 0, 1'b0, "R3 word index");
        // R4: odd word base with doubleword size
        issue(1'b0, 3'd1, 17'h00101, 3, 32'h0, 0, 1'b0, "R4 doubleword align indexed");
        issue(1'b0, 3'd0, 17'h00103, 3, 32'h0, 0, 1'b0, "R4 doubleword align plain");
        // R8: window boundary
        issue(1'b0, 3'd0, 17'h0000F, 2, 32'h0, 0, 1'b0, "R8 last window word");
        issue(1'b0, 3'd0, 17'h00010, 2, 32'h0, 0, 1'b0, "R8 first memory word");
        issue(1'b0, 3'd2, 17'h00000, 0, 32'h0, 0, 1'b0, "R8 byte in window");
        // R6/R7: indirect with junk in upper bits, post-indexed
        issue(1'b1, 3'd3, 17'h00055, 2, 32'hFFFE_0200, 2, 1'b0, "R7 indirect word");
        issue(1'b1, 3'd7, 17'h1FFFF, 3, 32'h0000_1235, 0, 1'b0, "R7 indirect doubleword");
        issue(1'b1, 3'd0, 17'h00020, 0, 32'h0000_0007, 1, 1'b0, "R7 indirect to window");
        // R9: start pulse while fetch is pending
        issue(1'b1, 3'd1, 17'h00ABC, 1, 32'h0000_0300, 4, 1'b1, "R9 busy start first result");
        repeat (6) @(negedge clk);
        chk(n_seen == n_issued, "R9 result count", 32'(n_seen), 32'(n_issued));
        chk(q_ea.size() == 0,   "R9 scoreboard empty", 32'(q_ea.size()), 32'd0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog expired", 32'(cyc), 32'(WD_CYCLES));
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule